// File: doc/BRIEF.md
# Scaled-Index Address Generator

This block forms the 32-bit target address of a load or store from an operand specifier that has already been decoded. It holds eight 32-bit general-purpose registers. From these it reads an optional base and an optional index. The index is shifted left by a 2-bit scale code, so it is multiplied by 1, 2, 4 or 8. The sum of the base, the scaled index and a displacement taken from the instruction becomes the address. The displacement can be absent, a sign-extended byte or a full 32-bit word.

Requests enter through a valid/ready handshake. The result sits in a single output register for one pipeline stage. It keeps its value until the consumer takes it. A small controller with two named states runs this stage:
- `PIPE_EMPTY`: no result is held.
- `PIPE_FULL`: a result waits for the consumer.

The controller has four transitions:
- `EMPTY->FULL`: a request is accepted.
- `FULL->FULL`: the output is stalled, or it is drained and a new request is accepted in the same cycle.
- `FULL->EMPTY`: the output is drained and no request arrives.
- `EMPTY->EMPTY`: idle.

Two operand combinations are illegal:
- a non-zero scale with no index;
- the reserved displacement size code.

Either one raises a flag and forces the address to zero.

Top module: `scaled_addr_gen`

## Requirements
- R1: For a legal request, the address is base term + (index term << scale) + displacement term, taken modulo 2^32. No overflow indication exists.
- R2: With `base_en` = 1, any selector 0 to 7 (4 included) supplies that register as the base. With `base_en` = 0, the base term is zero.
- R3: With `idx_en` = 1 and `idx_sel` = 4, the index term is zero and no illegal flag is raised. Selectors 0 to 3 and 5 to 7 supply that register, shifted by the scale.
- R4: `disp_size` selects the displacement term: 0 gives zero, 1 gives `disp[7:0]` sign-extended, 2 gives `disp[31:0]`. Code 3 is reserved: it sets `rsp_illegal` and gives address 0.
- R5: A `scale` other than 0 together with `idx_en` = 0 sets `rsp_illegal`, and `rsp_addr` is then 0.
- R6: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. Its result shows with `rsp_valid` = 1 right after that edge, exactly one clock later. Once drained with no new request, `rsp_valid` goes to 0.
- R7: While `rsp_valid` = 1 and `rsp_ready` = 0, the controller holds these outputs:
  - `rsp_addr` and `rsp_illegal` stay unchanged;
  - `req_ready` is 0;
  - later register writes do not alter the held result.
- R8: `req_ready` is 1 whenever the output is empty or is being consumed in that cycle. Back-to-back requests therefore complete one per clock.
- R9: A register write through `wr_en`/`wr_sel`/`wr_data` takes effect at the rising edge. A request accepted at that same edge reads the value held before the write.
- R10: After reset, `rsp_valid` = 0, `req_ready` = 1 and all eight registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 3 | Register to write |
| wr_data | input | 32 | Value to write |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| base_en | input | 1 | Use a base register |
| base_sel | input | 3 | Base register selector |
| idx_en | input | 1 | Use an index register |
| idx_sel | input | 3 | Index register selector, 4 means none |
| scale | input | 2 | Index shift amount 0 to 3 |
| disp_size | input | 2 | Displacement size: 0 none, 1 byte, 2 word, 3 reserved |
| disp | input | 32 | Displacement from the instruction |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 32 | Computed target address |
| rsp_illegal | output | 1 | Illegal operand combination |

## Verification
The assertions check the handshake on every cycle:
- the one-clock latency from acceptance to `rsp_valid`;
- the frozen result during a stall, with `req_ready` low while the output is blocked;
- a zero address whenever the illegal flag is set;
- raising or not raising the illegal flag in the cycle after an accepted request, according to its scale, index enable and size code.

The arithmetic of the address can only be shown by the bench's sweep. The sweep walks every combination of base and index enable and selector, scale and displacement size against register values written beforehand. Only directed scenarios can show the reset contents, the read-before-write ordering, and that a register written during a stall leaves the held result untouched.

// File: rtl/sag_pkg.sv
package sag_pkg;

    // Displacement size codes carried by the operand specifier.
    typedef enum logic [1:0] {
        DSZ_NONE = 2'd0,
        DSZ_BYTE = 2'd1,
        DSZ_WORD = 2'd2,
        DSZ_RSVD = 2'd3
    } disp_size_e;

    // Occupancy of the single output stage.
    typedef enum logic {
        PIPE_EMPTY = 1'b0,
        PIPE_FULL  = 1'b1
    } pipe_state_e;

endpackage

// File: rtl/sag_gpr_file.sv
module sag_gpr_file #(
    parameter int DATA_W = 32,
    parameter int NREG   = 8,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_a_sel,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [SEL_W-1:0]  rd_b_sel,
    output logic [DATA_W-1:0] rd_b_data
);

    logic [DATA_W-1:0] regs [NREG];

    // One storage element per register; write decode per entry.
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                regs[g] <= wr_data;
            end
        end
    end

    // Combinational read: a same-edge write is seen only after the edge.
    always_comb begin
        rd_a_data = regs[rd_a_sel];
        rd_b_data = regs[rd_b_sel];
    end

endmodule

// File: rtl/sag_term_calc.sv
module sag_term_calc
    import sag_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int SEL_W        = 3,
    parameter int SCALE_W      = 2,
    parameter int NO_INDEX_SEL = 4,
    parameter int BYTE_W       = 8
) (
    input  logic               base_en,
    input  logic [DATA_W-1:0]  base_val,
    input  logic               idx_en,
    input  logic [SEL_W-1:0]   idx_sel,
    input  logic [DATA_W-1:0]  idx_val,
    input  logic [SCALE_W-1:0] scale,
    input  logic [1:0]         disp_size,
    input  logic [DATA_W-1:0]  disp,
    output logic [DATA_W-1:0]  addr_next,
    output logic               illegal_next
);

    logic [DATA_W-1:0] base_term;
    logic [DATA_W-1:0] idx_term;
    logic [DATA_W-1:0] disp_term;
    logic              idx_is_none;
    logic              bad_scale;
    logic              bad_size;
    disp_size_e        dsz;

    assign dsz         = disp_size_e'(disp_size);
    assign idx_is_none = (idx_sel == SEL_W'(NO_INDEX_SEL));

    always_comb begin
        base_term = base_en ? base_val : '0;
    end

    always_comb begin
        if (idx_en && !idx_is_none) begin
            idx_term = idx_val << scale;
        end else begin
            idx_term = '0;
        end
    end

    always_comb begin
        bad_size = 1'b0;
        unique case (dsz)
            DSZ_NONE: disp_term = '0;
            DSZ_BYTE: disp_term = {{(DATA_W-BYTE_W){disp[BYTE_W-1]}}, disp[BYTE_W-1:0]};
            DSZ_WORD: disp_term = disp;
            DSZ_RSVD: begin
                disp_term = '0;
                bad_size  = 1'b1;
            end
        endcase
    end

    assign bad_scale    = (scale != '0) && !idx_en;
    assign illegal_next = bad_scale || bad_size;

    always_comb begin
        if (illegal_next) begin
            addr_next = '0;
        end else begin
            addr_next = base_term + idx_term + disp_term;
        end
    end

endmodule

// File: rtl/sag_pipe_ctrl.sv
module sag_pipe_ctrl
    import sag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    output logic out_valid,
    input  logic out_ready,
    output logic load
);

    pipe_state_e state_q;
    pipe_state_e state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PIPE_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIPE_EMPTY: begin
                if (in_valid) begin
                    state_d = PIPE_FULL;
                end
            end
            PIPE_FULL: begin
                if (out_ready && !in_valid) begin
                    state_d = PIPE_EMPTY;
                end
            end
        endcase
    end

    // Outputs.
    always_comb begin
        unique case (state_q)
            PIPE_EMPTY: begin
                out_valid = 1'b0;
                in_ready  = 1'b1;
            end
            PIPE_FULL: begin
                out_valid = 1'b1;
                in_ready  = out_ready;
            end
        endcase
        load = in_valid && in_ready;
    end

endmodule

// File: rtl/scaled_addr_gen.sv
module scaled_addr_gen
    import sag_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int NREG         = 8,
    parameter int SCALE_W      = 2,
    parameter int NO_INDEX_SEL = 4,
    localparam int SEL_W       = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               base_en,
    input  logic [SEL_W-1:0]   base_sel,
    input  logic               idx_en,
    input  logic [SEL_W-1:0]   idx_sel,
    input  logic [SCALE_W-1:0] scale,
    input  logic [1:0]         disp_size,
    input  logic [DATA_W-1:0]  disp,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [DATA_W-1:0]  rsp_addr,
    output logic               rsp_illegal
);

    logic [DATA_W-1:0] base_val;
    logic [DATA_W-1:0] idx_val;
    logic [DATA_W-1:0] addr_next;
    logic              illegal_next;
    logic              load;
    logic [DATA_W-1:0] addr_q;
    logic              illegal_q;

    sag_gpr_file #(
        .DATA_W (DATA_W),
        .NREG   (NREG)
    ) u_gpr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_a_sel  (base_sel),
        .rd_a_data (base_val),
        .rd_b_sel  (idx_sel),
        .rd_b_data (idx_val)
    );

    sag_term_calc #(
        .DATA_W       (DATA_W),
        .SEL_W        (SEL_W),
        .SCALE_W      (SCALE_W),
        .NO_INDEX_SEL (NO_INDEX_SEL)
    ) u_calc (
        .base_en      (base_en),
        .base_val     (base_val),
        .idx_en       (idx_en),
        .idx_sel      (idx_sel),
        .idx_val      (idx_val),
        .scale        (scale),
        .disp_size    (disp_size),
        .disp         (disp),
        .addr_next    (addr_next),
        .illegal_next (illegal_next)
    );

    sag_pipe_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .out_valid (rsp_valid),
        .out_ready (rsp_ready),
        .load      (load)
    );

    // Result register: written only when a request is accepted.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            illegal_q <= 1'b0;
        end else if (load) begin
            addr_q    <= addr_next;
            illegal_q <= illegal_next;
        end
    end

    assign rsp_addr    = addr_q;
    assign rsp_illegal = illegal_q;

endmodule

// File: rtl/sag_checker.sv
module sag_checker #(
    parameter int DATA_W  = 32,
    parameter int SCALE_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               idx_en,
    input logic [SCALE_W-1:0] scale,
    input logic [1:0]         disp_size,
    input logic               rsp_valid,
    input logic               rsp_ready,
    input logic [DATA_W-1:0]  rsp_addr,
    input logic               rsp_illegal
);

    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    assert_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready && !req_valid) |=> !rsp_valid);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_addr) && $stable(rsp_illegal)));

    assert_stall_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |-> !req_ready);

    assert_ready_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> req_ready);

    assert_illegal_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_illegal) |-> (rsp_addr == '0));

    assert_bad_scale_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && scale != '0 && !idx_en) |=> rsp_illegal);

    assert_bad_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && disp_size == 2'd3) |=> rsp_illegal);

    assert_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && idx_en && disp_size != 2'd3) |=> !rsp_illegal);

endmodule

bind scaled_addr_gen sag_checker #(
    .DATA_W  (DATA_W),
    .SCALE_W (SCALE_W)
) u_chk (.*);

// File: tb/sim_scaled_addr_gen.sv
module sim_scaled_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        base_en = 1'b0;
    logic [2:0]  base_sel = '0;
    logic        idx_en = 1'b0;
    logic [2:0]  idx_sel = '0;
    logic [1:0]  scale = '0;
    logic [1:0]  disp_size = '0;
    logic [31:0] disp = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_addr;
    logic        rsp_illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] rv [8];

    always #4 clk = ~clk;

    scaled_addr_gen u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [32:0] model(input logic be, input logic [2:0] bs,
                                          input logic ie, input logic [2:0] is,
                                          input logic [1:0] sc, input logic [1:0] ds,
                                          input logic [31:0] d);
        logic [31:0] b, ix, dt;
        logic ill;
        b  = be ? rv[bs] : 32'd0;
        ix = (ie && is != 3'd4) ? (rv[is] * (32'd1 << sc)) : 32'd0;
        case (ds)
            2'd1:    dt = {{24{d[7]}}, d[7:0]};
            2'd2:    dt = d;
            default: dt = 32'd0;
        endcase
        ill = (ds == 2'd3) || (sc != 2'd0 && !ie);
        return {ill, ill ? 32'd0 : (b + ix + dt)};
    endfunction

    task automatic set_req(input logic be, input logic [2:0] bs, input logic ie,
                           input logic [2:0] is, input logic [1:0] sc,
                           input logic [1:0] ds, input logic [31:0] d);
        base_en = be; base_sel = bs; idx_en = ie; idx_sel = is;
        scale = sc; disp_size = ds; disp = d; req_valid = 1'b1;
    endtask

    task automatic write_reg(input logic [2:0] s, input logic [31:0] v);
        wr_en = 1'b1; wr_sel = s; wr_data = v;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        rv[s] = v;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [32:0] e;
        string tag;
        int n;
        for (int i = 0; i < 8; i++) rv[i] = 32'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state and cleared registers
        chk("R10 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R10 req_ready", {31'd0, req_ready}, 32'd1);
        set_req(1'b1, 3'd6, 1'b1, 3'd3, 2'd2, 2'd0, 32'd0);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk("R10 regs zero", rsp_addr, 32'd0);
        @(posedge clk); @(negedge clk);

        for (int i = 0; i < 8; i++) write_reg(3'(i), 32'h8000_0003 + 32'(i) * 32'h1357_9BDF);

        // R1..R5, R6, R8: full sweep with back-to-back requests
        n = 0;
        for (int be = 0; be < 2; be++)
        for (int bs = 0; bs < 8; bs++)
        for (int ie = 0; ie < 2; ie++)
        for (int is = 0; is < 8; is++)
        for (int sc = 0; sc < 4; sc++)
        for (int ds = 0; ds < 4; ds++) begin
            logic [31:0] d;
            d = (32'h9E37_79B9 * 32'(n + 1)) ^ 32'(n);
            n++;
            set_req(1'(be), 3'(bs), 1'(ie), 3'(is), 2'(sc), 2'(ds), d);
            e = model(1'(be), 3'(bs), 1'(ie), 3'(is), 2'(sc), 2'(ds), d);
            @(posedge clk); @(negedge clk);
            if (ds == 3) tag = "R4 reserved size";
            else if (sc != 0 && ie == 0) tag = "R5 scale without index";
            else if (be == 0) tag = "R2 base off";
            else if (ie == 1 && is == 4) tag = "R3 no-index selector";
            else if (ds == 1) tag = "R4 byte disp";
            else tag = "R1 address sum";
            chk({tag, " addr"}, rsp_addr, e[31:0]);
            chk({tag, " illegal"}, {31'd0, rsp_illegal}, {31'd0, e[32]});
            chk("R6 valid one clock later", {31'd0, rsp_valid}, 32'd1);
            chk("R8 ready back-to-back", {31'd0, req_ready}, 32'd1);
        end
        req_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R6 drained", {31'd0, rsp_valid}, 32'd0);

        // R9: same-edge write and read sees the old value
        e = {1'b0, rv[2]};
        wr_en = 1'b1; wr_sel = 3'd2; wr_data = 32'hCAFE_0042;
        set_req(1'b1, 3'd2, 1'b0, 3'd0, 2'd0, 2'd0, 32'd0);
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; rv[2] = 32'hCAFE_0042;
        chk("R9 old value", rsp_addr, e[31:0]);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk("R9 new value", rsp_addr, 32'hCAFE_0042);
        @(posedge clk); @(negedge clk);

        // R7: stall holds the result; register write and pending request ignored
        rsp_ready = 1'b0;
        set_req(1'b1, 3'd1, 1'b1, 3'd7, 2'd3, 2'd1, 32'h0000_0080);
        e = model(1'b1, 3'd1, 1'b1, 3'd7, 2'd3, 2'd1, 32'h0000_0080);
        @(posedge clk); @(negedge clk);
        set_req(1'b1, 3'd5, 1'b0, 3'd0, 2'd0, 2'd2, 32'h0000_1000);
        wr_en = 1'b1; wr_sel = 3'd1; wr_data = 32'h1111_1111;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; rv[1] = 32'h1111_1111;
        for (int k = 0; k < 3; k++) begin
            chk("R7 held addr", rsp_addr, e[31:0]);
            chk("R7 held valid", {31'd0, rsp_valid}, 32'd1);
            chk("R7 ready low", {31'd0, req_ready}, 32'd0);
            @(posedge clk); @(negedge clk);
        end
        rsp_ready = 1'b1;
        e = model(1'b1, 3'd5, 1'b0, 3'd0, 2'd0, 2'd2, 32'h0000_1000);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk("R7 next after release", rsp_addr, e[31:0]);
        @(posedge clk); @(negedge clk);
        chk("R6 empty after release", {31'd0, rsp_valid}, 32'd0);

        done = 1'b1;
        finish_run();
    end

endmodule